// File: doc/BRIEF.md
# Two-Bank Maskable Interrupt Controller

The block gathers 64 peripheral interrupt lines into one request to the processor. The lines are split into two banks of 32. The low bank holds sources 0 to 31 and the high bank holds sources 32 to 63. A rising edge on a line latches a pending event bit in its bank. Software enables or blocks each source with a per-bit mask. It acknowledges an event by writing a one to the matching bit of that bank's clear register. It can also read the live state of every line.

Access is through a plain 32-bit register port with byte offsets. A read is requested for one cycle, and its data is registered and then held until the next read. The processor request output is high while any pending event has its mask bit set, in either bank.

Top module: `irq_ctrl2`

## Requirements
- R1: After reset all event bits and all mask bits are zero, `irq_o` is low and `rdata_o` is zero.
- R2: A rising edge on `src_i[n]` sets pending bit n. Sources 0 to 31 appear at bit n of the low-bank events register (offset 0x20). Sources 32 to 63 appear at bit n-32 of the high-bank events register (offset 0x10). A line that stays high does not set its bit again once it has been cleared.
- R3: Writing the low-bank mask (0x24) or the high-bank mask (0x14) stores the written word, and reading the same offset returns it. A mask bit of 1 enables its source.
- R4: Writing a word to the low-bank clear register (0x28) or the high-bank clear register (0x18) clears each pending bit where the word has a 1. Bits where the word has a 0 keep their value.
- R5: When a rising edge and a clear of the same bit happen in the same cycle, the bit ends up set.
- R6: The levels registers return the current raw source lines. The low bank is at 0x2C and the high bank is at 0x1C.
- R7: `irq_o` is high exactly when some event bit and its mask bit are both 1, in either bank.
- R8: Reads of a clear register, of any offset outside the eight bank registers, and of any address not aligned to a word all return zero.
- R9: Writes to the events and levels registers have no effect on any state.
- R10: `rdata_o` takes the addressed value at the clock edge where `re_i` is high and keeps that value while `re_i` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 64 | Raw interrupt source lines |
| we_i | input | 1 | Register write strobe |
| re_i | input | 1 | Register read strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Combined interrupt request to the processor |

## Verification
The assertions assume that the source lines are synchronous to `clk_i`. They also assume that a read and a write never fall in the same cycle, so that a clear and its readback are ordered. The stimulus changes sources, strobes, address and write data only on falling clock edges, and it issues one register access at a time. The edge detector therefore sees each source transition exactly once. The same-cycle case is produced on purpose by raising a line in the very cycle that carries its clear write.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;

  typedef enum logic [1:0] {
    REG_EV   = 2'd0,
    REG_MASK = 2'd1,
    REG_CLR  = 2'd2,
    REG_LVL  = 2'd3
  } reg_e;

  localparam int REGS_PER_BANK = 4;

  // bank 0 (sources 0..31) sits above bank 1 (sources 32..63)
  function automatic int bank_base(input int b);
    return (b == 0) ? 32'h20 : 32'h10;
  endfunction

endpackage

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] src_i,
  input  logic         mask_we_i,
  input  logic         clr_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] ev_o,
  output logic [W-1:0] mask_o,
  output logic [W-1:0] lvl_o,
  output logic         pend_o
);

  logic [W-1:0] src_q, ev_q, mask_q, rise, clr;

  assign rise = src_i & ~src_q;
  assign clr  = clr_we_i ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q  <= '0;
      ev_q   <= '0;
      mask_q <= '0;
    end else begin
      src_q <= src_i;
      ev_q  <= (ev_q & ~clr) | rise;  // new edge beats clear
      if (mask_we_i) mask_q <= wdata_i;
    end
  end

  assign ev_o   = ev_q;
  assign mask_o = mask_q;
  assign lvl_o  = src_i;
  assign pend_o = |(ev_q & mask_q);

endmodule

// File: rtl/irq_rd_mux.sv
module irq_rd_mux
  import irq_ctrl_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [REGS_PER_BANK-1:0] hit_i,
  input  logic [W-1:0]             ev_i,
  input  logic [W-1:0]             mask_i,
  input  logic [W-1:0]             lvl_i,
  output logic [W-1:0]             data_o
);

  always_comb begin
    data_o = '0;
    if (hit_i[REG_EV])   data_o = ev_i;
    if (hit_i[REG_MASK]) data_o = mask_i;
    if (hit_i[REG_LVL])  data_o = lvl_i;
  end

endmodule

// File: rtl/irq_ctrl2.sv
module irq_ctrl2
  import irq_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BANK_W = 32,
  parameter int NBANK  = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NBANK*BANK_W-1:0] src_i,
  input  logic                    we_i,
  input  logic                    re_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [BANK_W-1:0]       wdata_i,
  output logic [BANK_W-1:0]       rdata_o,
  output logic                    irq_o
);

  localparam int NSRC = NBANK * BANK_W;

  logic [NSRC-1:0]              ev_all, mask_all;
  logic [NBANK-1:0]             pend;
  logic [NBANK-1:0][BANK_W-1:0] rd_bank;
  logic [BANK_W-1:0]            rd_next, rdata_q;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [REGS_PER_BANK-1:0] hit;
    logic [BANK_W-1:0]        lvl;

    for (genvar k = 0; k < REGS_PER_BANK; k++) begin : g_hit
      assign hit[k] = (addr_i == ADDR_W'(bank_base(b) + 4 * k));
    end

    irq_bank #(.W(BANK_W)) u_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .src_i     (src_i[b*BANK_W +: BANK_W]),
      .mask_we_i (we_i & hit[REG_MASK]),
      .clr_we_i  (we_i & hit[REG_CLR]),
      .wdata_i   (wdata_i),
      .ev_o      (ev_all[b*BANK_W +: BANK_W]),
      .mask_o    (mask_all[b*BANK_W +: BANK_W]),
      .lvl_o     (lvl),
      .pend_o    (pend[b])
    );

    irq_rd_mux #(.W(BANK_W)) u_rd (
      .hit_i  (hit),
      .ev_i   (ev_all[b*BANK_W +: BANK_W]),
      .mask_i (mask_all[b*BANK_W +: BANK_W]),
      .lvl_i  (lvl),
      .data_o (rd_bank[b])
    );
  end

  always_comb begin
    rd_next = '0;
    for (int b = 0; b < NBANK; b++) rd_next |= rd_bank[b];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   rdata_q <= '0;
    else if (re_i) rdata_q <= rd_next;
  end

  assign rdata_o = rdata_q;
  assign irq_o   = |pend;

endmodule

// File: rtl/irq_ctrl2_chk.sv
module irq_ctrl2_chk
  import irq_ctrl_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int BANK_W = 32,
  parameter int NBANK  = 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [NBANK*BANK_W-1:0] src_i,
  input logic                    we_i,
  input logic                    re_i,
  input logic [ADDR_W-1:0]       addr_i,
  input logic [BANK_W-1:0]       wdata_i,
  input logic [BANK_W-1:0]       rdata_o,
  input logic                    irq_o,
  input logic [NBANK*BANK_W-1:0] ev_all,
  input logic [NBANK*BANK_W-1:0] mask_all
);

  localparam int NSRC = NBANK * BANK_W;

  logic [NSRC-1:0] src_d, rise_c, clr_c;
  logic            mapped_c, clr_hit_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_d <= '0;
    else         src_d <= src_i;
  end

  assign rise_c = src_i & ~src_d;

  always_comb begin
    clr_c     = '0;
    mapped_c  = 1'b0;
    clr_hit_c = 1'b0;
    for (int b = 0; b < NBANK; b++) begin
      for (int k = 0; k < REGS_PER_BANK; k++)
        if (addr_i == ADDR_W'(bank_base(b) + 4 * k)) mapped_c = 1'b1;
      if (addr_i == ADDR_W'(bank_base(b) + 8)) begin
        clr_hit_c = 1'b1;
        if (we_i) clr_c[b*BANK_W +: BANK_W] = wdata_i;
      end
    end
  end

  assert_edge_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_c != '0) |=> ((ev_all & $past(rise_c)) == $past(rise_c)));

  assert_no_spurious_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((ev_all & ~$past(ev_all) & ~$past(rise_c)) == '0));

  assert_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_c & ~rise_c) != '0) |=> ((ev_all & $past(clr_c & ~rise_c)) == '0));

  assert_edge_wins_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_c & rise_c) != '0) |=> ((ev_all & $past(clr_c & rise_c)) == $past(clr_c & rise_c)));

  assert_mask_only_by_write_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mask_all));

  assert_irq_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_all == '0) |-> !irq_o);

  assert_irq_on_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((ev_all & mask_all) != '0) |-> irq_o);

  assert_zero_read_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (re_i && (!mapped_c || clr_hit_c)) |=> (rdata_o == '0));

  assert_rdata_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !re_i |=> $stable(rdata_o));

endmodule

bind irq_ctrl2 irq_ctrl2_chk #(
  .ADDR_W(ADDR_W),
  .BANK_W(BANK_W),
  .NBANK (NBANK)
) u_chk (.*);

// File: tb/test_irq_ctrl2.sv
module test_irq_ctrl2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic        we = 1'b0, re = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0]  a;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sb[$];
  logic took_rd = 1'b0;

  always #4 clk = ~clk;

  irq_ctrl2 i_irq_ctrl2 (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .we_i(we), .re_i(re),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); re = 1'b1; addr = a;
    sb.push_back('{a: a, exp: e, tag: tag});
    @(negedge clk); re = 1'b0;
  endtask

  // monitor: compare each completed read
  always @(posedge clk) took_rd <= re;
  always @(negedge clk) begin
    if (took_rd && sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      chk(rdata === it.exp, it.tag, rdata, it.exp);
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq === 1'b0, "R1 irq after reset", {31'd0, irq}, 0);
    chk(rdata === 32'd0, "R1 rdata after reset", rdata, 0);
    rd(8'h20, 0, "R1 events low");
    rd(8'h24, 0, "R1 mask low");
    rd(8'h10, 0, "R1 events high");
    rd(8'h14, 0, "R1 mask high");

    @(negedge clk); src[3] = 1'b1; src[40] = 1'b1;
    rd(8'h20, 32'h8, "R2 low bank edge");
    rd(8'h10, 32'h100, "R2 high bank edge");
    chk(irq === 1'b0, "R7 masked off", {31'd0, irq}, 0);

    wr(8'h24, 32'h8);
    chk(irq === 1'b1, "R7 low bank enabled", {31'd0, irq}, 1);
    rd(8'h24, 32'h8, "R3 mask readback");

    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h2C, 32'h0000_FFFF);
    rd(8'h20, 32'h8, "R9 events write ignored");
    wr(8'h10, 32'h0);
    rd(8'h10, 32'h100, "R9 high events write ignored");
    rd(8'h2C, 32'h8, "R6 low levels");
    rd(8'h1C, 32'h100, "R6 high levels");

    wr(8'h28, 32'h0);
    rd(8'h20, 32'h8, "R4 zero clear no effect");
    wr(8'h28, 32'h8);
    rd(8'h20, 32'h0, "R4 clear bit 3");
    chk(irq === 1'b0, "R7 cleared", {31'd0, irq}, 0);
    rd(8'h20, 32'h0, "R2 held level no re-set");

    rd(8'h28, 0, "R8 clear reads zero");
    rd(8'h18, 0, "R8 high clear reads zero");
    rd(8'h30, 0, "R8 unmapped");
    rd(8'h21, 0, "R8 misaligned");

    // edge and clear in the same cycle
    @(negedge clk); src[3] = 1'b0;
    @(negedge clk); src[3] = 1'b1; we = 1'b1; addr = 8'h28; wdata = 32'h8;
    @(negedge clk); we = 1'b0;
    rd(8'h20, 32'h8, "R5 edge beats clear");
    wr(8'h28, 32'h8);

    wr(8'h14, 32'h100);
    chk(irq === 1'b1, "R7 high bank enabled", {31'd0, irq}, 1);
    wr(8'h18, 32'h100);
    chk(irq === 1'b0, "R7 high bank cleared", {31'd0, irq}, 0);

    @(negedge clk); src[63] = 1'b1;
    rd(8'h10, 32'h8000_0000, "R2 source 63");
    @(negedge clk); addr = 8'h24;
    repeat (2) @(negedge clk);
    chk(rdata === 32'h8000_0000, "R10 rdata held", rdata, 32'h8000_0000);

    @(negedge clk); src[3] = 1'b0;
    rd(8'h2C, 32'h0, "R6 level dropped");

    repeat (3) @(negedge clk);
    finish_run();
  end

endmodule